// File: doc/BRIEF.md
# PWM Duty Cycle Meter

The meter watches one pulse-width-modulated input, sampled on the system clock only in cycles where a sample-enable input is high. It counts how many enabled samples the signal stays low and how many it stays high. Each completed period yields the duty cycle twice: as a whole-number percentage and as a byte fraction of 256. The period length in samples and a running count of periods come with each result. A run-time select input picks which transition opens a period: a rising one, or a falling one.

The input passes through a two-flop synchroniser before edge detection. A low interval is measured at each rising transition and a high interval at each falling transition. A result is produced only after an interval start has been recorded, so the leading partial period never reports. Both quotients come from a pair of sequential restoring dividers. A single-cycle strobe marks a new result. While a division is in progress, a further period-boundary transition still updates the measurements and the period count, but it does not start a new result.

Top module: `pwm_duty_meter`

## Requirements
- R1: The input level used by the measurement is the value of `pwmIn` two clock cycles earlier, through two flops. A clock cycle with `sampleEn` low is not a sample: it neither counts time nor detects a transition.
- R2: At a transition of the synchronised level, the interval just ended is the number of enabled samples since the previous transition; the first transition after reset counts from the first enabled sample after reset. The interval is the low time at a rising transition and the high time at a falling transition.
- R3: With `fallStart` = 0 a rising transition is the period boundary; with `fallStart` = 1 a falling transition is. `fallStart` is read at each sample and may change at run time.
- R4: A boundary transition starts a result only if some non-boundary transition has happened since reset, so no result appears for the leading partial period.
- R5: `dutyPct` = floor(100 * H / (H + L)), where H and L are the latest high and low times at the boundary transition.
- R6: `dutyByte` = floor(256 * H / (H + L)), limited to 255 when that value is 256 (possible only when L is 0).
- R7: `periodLen` = H + L for the same result.
- R8: An internal period counter increments at every boundary transition, whether or not a result is started. `periodCount` shows its value just after the transition that started the result.
- R9: `resultValid` is high for exactly one cycle per result. `dutyPct`, `dutyByte`, `periodLen` and `periodCount` change only in the cycle that `resultValid` is high.
- R10: A boundary transition that arrives while a result is still being computed produces no result of its own. The measurements and the period counter still update.
- R11: Each interval saturates at 2^CNT_W - 1 samples instead of wrapping.
- R12: After reset, `resultValid` is 0 and all result outputs read 0. The high and low times start at 1, and the previous level starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | Marks a clock cycle as a measurement sample |
| pwmIn | input | 1 | Asynchronous PWM input |
| fallStart | input | 1 | 0: period opens on a rising transition, 1: on a falling transition |
| resultValid | output | 1 | One-cycle strobe for a new result |
| dutyPct | output | 7 | Duty cycle in whole percent (0 to 100) |
| dutyByte | output | 8 | Duty cycle as a fraction of 256 (0 to 255) |
| periodLen | output | CNT_W+1 | High plus low time, in samples |
| periodCount | output | PCNT_W | Period count at the boundary that produced the result |

## Verification
A boundary transition can arrive in the same cycle window as a running division. The bench provokes this with a burst of 2-sample high and low phases, so a second rising boundary follows only four cycles after the first. It then expects no result for the second boundary, and it expects the next result to carry a period count that has advanced by two. The pass or fail decision uses the scoreboard's expected queue. Sample-enable gaps are also tested in the same runs: an alternating enable pattern is applied while transitions are still being detected, so sample counting and edge detection both happen under a gated enable.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;

  // Strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic measLow;   // store elapsed time as low time
    logic measHigh;  // store elapsed time as high time
    logic boundary;  // period boundary transition
    logic launch;    // start both divisions this cycle
    logic publish;   // load the result registers
  } ctlStrobes_t;

endpackage

// File: rtl/pwm_restoring_div.sv
module pwm_restoring_div #(
  parameter int NUM_W = 17,
  parameter int DEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] remReg;
  logic [DEN_W-1:0] denReg;
  logic [NUM_W-1:0] qReg;
  logic [CW-1:0]    left;
  logic [DEN_W:0]   trial;
  logic             fits;
  logic [DEN_W:0]   diff;

  always_comb begin
    trial = {remReg, qReg[NUM_W-1]};
    fits  = trial >= {1'b0, denReg};
    diff  = trial - {1'b0, denReg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remReg <= '0;
      denReg <= '0;
      qReg   <= '0;
      left   <= '0;
      done   <= 1'b0;
    end else if (start) begin
      remReg <= '0;
      denReg <= denom;
      qReg   <= numer;
      left   <= CW'(NUM_W);
      done   <= 1'b0;
    end else if (left != '0) begin
      remReg <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      qReg   <= {qReg[NUM_W-2:0], fits};
      left   <= left - 1'b1;
      done   <= (left == CW'(1));
    end else begin
      done   <= 1'b0;
    end
  end

  assign busy = (left != '0);
  assign quot = qReg;

  // R5
  rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remReg < denReg));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/pwm_meas_ctrl.sv
module pwm_meas_ctrl
  import pwm_meas_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        edgeHit,
  input  logic        edgeRise,
  input  logic        fallStart,
  input  logic        divBusy,
  input  logic        divDone,
  output logic        resultValid,
  output ctlStrobes_t ctl
);
  logic pending;
  logic startSeen;
  logic isBoundary;

  // a rising edge bounds the period when fallStart=0, a falling edge when 1
  assign isBoundary = edgeHit & (edgeRise ^ fallStart);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      startSeen   <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      pending     <= isBoundary & startSeen & ~pending & ~divBusy;
      if (edgeHit & ~isBoundary) startSeen <= 1'b1;
      resultValid <= divDone;
    end
  end

  always_comb begin
    ctl.measLow  = edgeHit & edgeRise;
    ctl.measHigh = edgeHit & ~edgeRise;
    ctl.boundary = isBoundary;
    ctl.launch   = pending;
    ctl.publish  = divDone;
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);

  // R10
  launch_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> divBusy);

  // R4
  no_early_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !startSeen |=> !pending);

endmodule

// File: rtl/pwm_meas_datapath.sv
module pwm_meas_datapath
  import pwm_meas_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PCNT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleEn,
  input  logic              pwmIn,
  input  ctlStrobes_t       ctl,
  output logic              edgeHit,
  output logic              edgeRise,
  output logic              divBusy,
  output logic              divDone,
  output logic [6:0]        dutyPct,
  output logic [7:0]        dutyByte,
  output logic [CNT_W:0]    periodLen,
  output logic [PCNT_W-1:0] periodCount
);
  localparam int SUM_W = CNT_W + 1;
  localparam int NUM_W = CNT_W + 9;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLvl;
  logic                   oldLevel;
  logic [CNT_W-1:0]       elapsed;
  logic [CNT_W-1:0]       highCnt;
  logic [CNT_W-1:0]       lowCnt;
  logic [PCNT_W-1:0]      periodCnt;
  logic [PCNT_W-1:0]      launchCnt;
  logic [SUM_W-1:0]       launchLen;
  logic [SUM_W-1:0]       sumHL;
  logic [NUM_W-1:0]       quot  [2];
  logic [1:0]             busyV;
  logic [1:0]             doneV;

  // input synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], pwmIn};
  end
  assign syncLvl  = syncQ[SYNC_STAGES-1];
  assign edgeHit  = sampleEn & (syncLvl != oldLevel);
  assign edgeRise = syncLvl;

  // interval measurement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oldLevel <= 1'b0;
      elapsed  <= '0;
      highCnt  <= CNT_W'(1);
      lowCnt   <= CNT_W'(1);
    end else if (sampleEn) begin
      oldLevel <= syncLvl;
      if (edgeHit)               elapsed <= CNT_W'(1);
      else if (elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
      if (ctl.measLow)  lowCnt  <= elapsed;
      if (ctl.measHigh) highCnt <= elapsed;
    end
  end

  assign sumHL = SUM_W'(highCnt) + SUM_W'(lowCnt);

  // period bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodCnt <= '0;
      launchCnt <= '0;
      launchLen <= '0;
    end else begin
      if (ctl.boundary) periodCnt <= periodCnt + 1'b1;
      if (ctl.launch) begin
        launchCnt <= periodCnt;
        launchLen <= sumHL;
      end
    end
  end

  // one divider per scale: index 0 percent, index 1 byte
  for (genvar g = 0; g < 2; g++) begin : g_div
    localparam int SCALE = (g == 0) ? 100 : 256;
    logic [NUM_W-1:0] numer;
    assign numer = NUM_W'(highCnt) * NUM_W'(SCALE);
    pwm_restoring_div #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (ctl.launch),
      .numer (numer),
      .denom (sumHL),
      .busy  (busyV[g]),
      .done  (doneV[g]),
      .quot  (quot[g])
    );
  end
  assign divBusy = busyV[0];
  assign divDone = doneV[0];

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dutyPct     <= '0;
      dutyByte    <= '0;
      periodLen   <= '0;
      periodCount <= '0;
    end else if (ctl.publish) begin
      dutyPct     <= quot[0][6:0];
      dutyByte    <= (quot[1] > NUM_W'(255)) ? 8'hFF : quot[1][7:0];
      periodLen   <= launchLen;
      periodCount <= launchCnt;
    end
  end

  // R11
  elapsed_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleEn && !edgeHit && elapsed == CNT_MAX) |=> (elapsed == CNT_MAX));

  // R8
  period_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.boundary |=> (periodCnt == PCNT_W'($past(periodCnt) + 1'b1)));

  // R5
  pct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.publish |-> (quot[0] <= NUM_W'(100)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.publish |=> ($stable(dutyPct) && $stable(dutyByte) && $stable(periodLen)));

  // R6
  byte_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneV[0] |-> doneV[1]);

endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter
  import pwm_meas_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleEn,
  input  logic              pwmIn,
  input  logic              fallStart,
  output logic              resultValid,
  output logic [6:0]        dutyPct,
  output logic [7:0]        dutyByte,
  output logic [CNT_W:0]    periodLen,
  output logic [PCNT_W-1:0] periodCount
);
  ctlStrobes_t ctl;
  logic        edgeHit;
  logic        edgeRise;
  logic        divBusy;
  logic        divDone;

  pwm_meas_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .edgeHit     (edgeHit),
    .edgeRise    (edgeRise),
    .fallStart   (fallStart),
    .divBusy     (divBusy),
    .divDone     (divDone),
    .resultValid (resultValid),
    .ctl         (ctl)
  );

  pwm_meas_datapath #(.CNT_W(CNT_W), .PCNT_W(PCNT_W), .SYNC_STAGES(2)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .sampleEn    (sampleEn),
    .pwmIn       (pwmIn),
    .ctl         (ctl),
    .edgeHit     (edgeHit),
    .edgeRise    (edgeRise),
    .divBusy     (divBusy),
    .divDone     (divDone),
    .dutyPct     (dutyPct),
    .dutyByte    (dutyByte),
    .periodLen   (periodLen),
    .periodCount (periodCount)
  );

endmodule

// File: tb/pwm_duty_meter_tb.sv
module pwm_duty_meter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int PCNT_W     = 16;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int BUSY_GAP   = 30;

  typedef struct {
    int pct;
    int byteVal;
    int len;
    int cnt;
  } expItem_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleEn = 1'b0;
  logic pwmIn = 1'b0;
  logic fallStart = 1'b0;
  logic resultValid;
  logic [6:0] dutyPct;
  logic [7:0] dutyByte;
  logic [CNT_W:0] periodLen;
  logic [PCNT_W-1:0] periodCount;

  int checks = 0;
  int fails = 0;
  expItem_t expQ[$];

  // reference model state
  int b1, b2, sampNo, oldPin, lastEdge, hiT, loT, pCount, cyc, lastLaunch;
  bit startSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_duty_meter #(.CNT_W(CNT_W), .PCNT_W(PCNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .pwmIn(pwmIn),
    .fallStart(fallStart), .resultValid(resultValid), .dutyPct(dutyPct),
    .dutyByte(dutyByte), .periodLen(periodLen), .periodCount(periodCount)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CNT_MAX) ? CNT_MAX : v;
  endfunction

  // one clock: drive, then update the model with the level two cycles old (R1)
  task automatic tick(input bit lvl, input bit en);
    int v;
    @(negedge clk);
    pwmIn = lvl;
    sampleEn = en;
    @(posedge clk);
    v = b2;
    b2 = b1;
    b1 = lvl;
    cyc++;
    if (en) begin
      if (v != oldPin) begin
        bit bnd;
        if (oldPin == 0) loT = sat(sampNo - lastEdge); // R2 low at rise
        else             hiT = sat(sampNo - lastEdge); // R2 high at fall, R11
        bnd = (oldPin == int'(fallStart));             // R3
        if (bnd) begin
          pCount++;                                    // R8
          if (startSeen && (cyc - lastLaunch) >= BUSY_GAP) begin // R4, R10
            expItem_t e;
            int b;
            e.pct = (100 * hiT) / (hiT + loT);         // R5
            b = (256 * hiT) / (hiT + loT);
            e.byteVal = (b > 255) ? 255 : b;           // R6
            e.len = hiT + loT;                         // R7
            e.cnt = pCount % (1 << PCNT_W);
            expQ.push_back(e);
            lastLaunch = cyc;
          end
        end else begin
          startSeen = 1'b1;
        end
        lastEdge = sampNo;
        oldPin = v;
      end
      sampNo++;
    end
  endtask

  task automatic phase(input bit lvl, input int n, input bit alt);
    for (int i = 0; i < n; i++) tick(lvl, alt ? bit'(i % 2) : 1'b1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    sampleEn = 1'b0;
    pwmIn = 1'b0;
    b1 = 0; b2 = 0; sampNo = 0; oldPin = 0; lastEdge = 0;
    hiT = 1; loT = 1; pCount = 0; cyc = 0; lastLaunch = -1000;
    startSeen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resultValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R4/R10", "unexpected result", int'(dutyPct), -1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(int'(dutyPct) == e.pct, "R5", "dutyPct", int'(dutyPct), e.pct);
        chk(int'(dutyByte) == e.byteVal, "R6", "dutyByte", int'(dutyByte), e.byteVal);
        chk(int'(periodLen) == e.len, "R7", "periodLen", int'(periodLen), e.len);
        chk(int'(periodCount) == e.cnt, "R8", "periodCount", int'(periodCount), e.cnt);
      end
      @(negedge clk);
      chk(resultValid == 1'b0, "R9", "strobe width", int'(resultValid), 0);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stimulus
    fallStart = 1'b0;
    doReset();
    @(negedge clk);
    // R12 reset state
    chk(resultValid == 1'b0, "R12", "resultValid", int'(resultValid), 0);
    chk(dutyPct == 0, "R12", "dutyPct", int'(dutyPct), 0);
    chk(dutyByte == 0, "R12", "dutyByte", int'(dutyByte), 0);
    chk(periodLen == 0, "R12", "periodLen", int'(periodLen), 0);
    chk(periodCount == 0, "R12", "periodCount", int'(periodCount), 0);

    // rising-boundary periods, R2 R3 R4 R5
    phase(0, 10, 0);
    phase(1, 30, 0); phase(0, 70, 0);
    phase(1, 50, 0); phase(0, 50, 0);
    phase(1, 13, 0); phase(0, 40, 0);
    // gated sampling, R1
    phase(1, 60, 1); phase(0, 90, 1);
    phase(1, 45, 0); phase(0, 45, 0);
    // boundary during division, R10
    phase(1, 2, 0); phase(0, 2, 0);
    phase(1, 2, 0); phase(0, 60, 0);
    // saturation of high and low, R11
    phase(1, 300, 0); phase(0, 40, 0);
    phase(1, 30, 0); phase(0, 400, 0);
    phase(1, 40, 0); phase(0, 50, 0);
    // switch to falling boundary at run time, R3
    fallStart = 1'b1;
    phase(1, 60, 0); phase(0, 45, 0);
    phase(1, 20, 0); phase(0, 70, 0);
    phase(1, 40, 0);
    phase(0, 40, 0);
    chk(expQ.size() == 0, "R10", "pending results", expQ.size(), 0);

    // zero low time: byte limit, R6 with falling boundary
    fallStart = 1'b1;
    doReset();
    tick(1, 0); tick(1, 0); tick(1, 0);
    phase(1, 20, 0); phase(0, 40, 0);
    phase(1, 40, 0); phase(0, 40, 0);
    phase(1, 40, 0);
    chk(expQ.size() == 0, "R4", "pending results", expQ.size(), 0);

    // leading partial period: no result, R4
    fallStart = 1'b0;
    doReset();
    phase(0, 5, 0); phase(1, 40, 0);
    phase(0, 40, 0);
    chk(expQ.size() == 0, "R4", "pending results", expQ.size(), 0);
    chk(resultValid == 1'b0, "R4", "no result", int'(resultValid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule